// File: doc/BRIEF.md
# Dual-Channel Buffered PWM Timer

This block is a 16-bit up-counter with a programmable terminal value and two channels that can each capture the count on an input edge or flag a compare match. Setting a link bit in channel 0's control register joins both channels into one PWM generator. In that mode the duty value used by the comparator is a shadow copy, which reloads only at a counter wrap. It is taken from whichever compare register software wrote last, so a new duty never cuts into a period that has already started.

The output rises on a wrap when toggle-on-wrap is enabled and falls on the active compare match. If toggle-on-wrap is disabled the output stays at 0%. If the full-duty bit and toggle-on-wrap are both set, compare events are ignored and the output stays high. The overflow flag and the channel flags each have an interrupt enable. A flag clears only after software has read it set and then writes 0 to it. An external stop input freezes the timer without losing any state. A break input also halts counting, and during break flags can be cleared only when a separate permit input is high.

A small register port gives software access. Reads are combinational on the address; writes take effect at the clock edge.

Top module: `dualpwm_timer`

## Requirements
- R1: While running, the count rises by one per enabled clock and returns to 0 on the clock after it equals the terminal value (address 1, reset value 0xFFFF), so a period lasts terminal+1 counts; the count is readable at address 6.
- R2: The overflow flag (address 0 bit 0) sets on a wrap; `irq_ovf_o` is high only while that flag and its enable (address 0 bit 1) are both 1; address 0 bit 2 enables counting.
- R3: A flag clears only when a write of 0 to its bit follows a read of its register that saw the flag set; writing 1, or writing 0 without such a read, leaves it set.
- R4: When a flag-setting event and a valid clear of the same flag fall on the same clock, the flag stays set.
- R5: While `brk_i` is high the count does not advance, and flags cannot be cleared unless `brk_clr_en_i` is high.
- R6: While `stop_i` is high the count and all registers keep their values; counting resumes from the held value once it drops.
- R7: With the output driven (control bit 2 link or bit 3 compare mode, channel 0 at address 4), a wrap with toggle-on-wrap (bit 4) set drives `pwm_o` high and a compare match drives it low; with duty value D and terminal M, the output is high for D+1 of every M+1 counts.
- R8: With toggle-on-wrap clear, `pwm_o` never rises, which gives 0% duty.
- R9: With full-duty (bit 5) and toggle-on-wrap both set, compare matches are ignored and `pwm_o` stays high once it has risen, which gives 100% duty.
- R10: In linked mode, channel 0's compare register (address 2) sets the duty at first. A write to either compare register (address 2 or 3) takes effect only at the next wrap, which hands control to the register written last.
- R11: A channel flag (bit 0 of address 4 or 5) sets on a compare match of the channel in control or, in capture mode (bit 3 clear, link off), on a rising `cap_i` edge, which also copies the count into that channel's compare register; `irq_ch_o[i]` requires the channel enable (bit 1).
- R12: Reset clears the count, all flags, enables and control bits, sets the terminal value to 0xFFFF and drives `pwm_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_i | input | 1 | Freeze request, keeps all state |
| brk_i | input | 1 | Break condition, halts counting |
| brk_clr_en_i | input | 1 | Permits flag clearing during break |
| cap_i | input | 2 | Capture inputs, one per channel |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (arms flag clearing) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data |
| pwm_o | output | 1 | PWM output |
| irq_ovf_o | output | 1 | Overflow interrupt request |
| irq_ch_o | output | 2 | Channel interrupt requests |

## Verification
A wrap that sets the overflow flag can land on the same clock as software's write of 0 that would clear it. The bench provokes this by reading the flag to arm the clear, parking the count at the terminal value, and then lifting the stop input on the same clock as the clearing write. It then reads the flag back and expects it still set. A compare match and a wrap can also meet when the duty equals the terminal value, and the wrap's rise takes priority.

// File: rtl/dpt_pkg.sv
package dpt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_HALT  = 2'd2
    } tmr_st_t;

    localparam int AW = 3;

    localparam logic [AW-1:0] RA_MAIN = 3'd0;
    localparam logic [AW-1:0] RA_TERM = 3'd1;
    localparam logic [AW-1:0] RA_CMP0 = 3'd2;
    localparam logic [AW-1:0] RA_CMP1 = 3'd3;
    localparam logic [AW-1:0] RA_CTL0 = 3'd4;
    localparam logic [AW-1:0] RA_CTL1 = 3'd5;
    localparam logic [AW-1:0] RA_CNT  = 3'd6;

    localparam int CB_FLAG = 0;
    localparam int CB_IE   = 1;
    localparam int CB_LINK = 2;
    localparam int CB_OCM  = 3;
    localparam int CB_TOV  = 4;
    localparam int CB_MAX  = 5;
    localparam int CTL_W   = 6;

    localparam int MB_FLAG = 0;
    localparam int MB_IE   = 1;
    localparam int MB_RUN  = 2;
endpackage

// File: rtl/dpt_count.sv
module dpt_count
    import dpt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_en,
    input  logic         stop_i,
    input  logic         brk_i,
    input  logic [W-1:0] term_i,
    output logic [W-1:0] cnt_o,
    output logic         tick_o,
    output logic         wrap_o
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    tmr_st_t st_q, st_d;
    logic    frozen;
    logic [W-1:0] cnt_q;

    assign frozen = stop_i || brk_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (run_en) st_d = frozen ? ST_HALT : ST_COUNT;
            ST_COUNT: if (!run_en) st_d = ST_IDLE;
                      else if (frozen) st_d = ST_HALT;
            ST_HALT:  if (!run_en) st_d = ST_IDLE;
                      else if (!frozen) st_d = ST_COUNT;
            default:  st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        tick_o = (st_q != ST_IDLE) && run_en && !frozen;
        wrap_o = tick_o && (cnt_q == term_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (wrap_o) cnt_q <= '0;
        else if (tick_o) cnt_q <= cnt_q + ONE;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/dpt_chan.sv
module dpt_chan
    import dpt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_we,
    input  logic             ctl_we,
    input  logic             ctl_re,
    input  logic             clr_ok,
    input  logic [W-1:0]     wdata,
    input  logic             cap_i,
    input  logic             cap_en,
    input  logic [W-1:0]     cnt_i,
    input  logic             hit_i,
    output logic [W-1:0]     cmp_o,
    output logic [CTL_W-1:0] ctl_o,
    output logic             irq_o
);
    logic [W-1:0]       cmp_q;
    logic [CTL_W-1:1]   cfg_q;
    logic               flag_q, arm_q, cap_q;
    logic               rise, clr;

    assign rise = cap_i && !cap_q && cap_en;
    assign clr  = ctl_we && !wdata[CB_FLAG] && arm_q && clr_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q  <= '0;
            cfg_q  <= '0;
            flag_q <= 1'b0;
            arm_q  <= 1'b0;
            cap_q  <= 1'b0;
        end else begin
            cap_q <= cap_i;
            if (rise)        cmp_q <= cnt_i;
            else if (cmp_we) cmp_q <= wdata;
            if (ctl_we)      cfg_q <= wdata[CTL_W-1:1];
            if (hit_i || rise) flag_q <= 1'b1;
            else if (clr)      flag_q <= 1'b0;
            if (clr)                arm_q <= 1'b0;
            else if (ctl_re && flag_q) arm_q <= 1'b1;
        end
    end

    assign cmp_o = cmp_q;
    assign ctl_o = {cfg_q, flag_q};
    assign irq_o = flag_q && cfg_q[CB_IE];
endmodule

// File: rtl/dpt_pwm.sv
module dpt_pwm #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         link,
    input  logic         ocm0,
    input  logic         ocm1,
    input  logic         tov,
    input  logic         maxd,
    input  logic [W-1:0] cmp0,
    input  logic [W-1:0] cmp1,
    input  logic         wr0,
    input  logic         wr1,
    input  logic [W-1:0] cnt,
    input  logic         tick,
    input  logic         wrap,
    output logic         pwm_o,
    output logic [1:0]   hit_o
);
    logic [W-1:0] duty_q;
    logic         act_q, last_q, pwm_q;
    logic         drive, duty_hit, out_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            duty_q <= '0;
            act_q  <= 1'b0;
            last_q <= 1'b0;
        end else if (!link) begin
            duty_q <= cmp0;
            act_q  <= 1'b0;
            last_q <= 1'b0;
        end else begin
            if (wr0)      last_q <= 1'b0;
            else if (wr1) last_q <= 1'b1;
            if (wrap) begin
                act_q  <= last_q;
                duty_q <= last_q ? cmp1 : cmp0;
            end
        end
    end

    always_comb begin
        duty_hit = tick && (cnt == duty_q);
        if (link) begin
            hit_o[0] = duty_hit && !act_q;
            hit_o[1] = duty_hit && act_q;
            out_hit  = duty_hit;
        end else begin
            hit_o[0] = tick && ocm0 && (cnt == cmp0);
            hit_o[1] = tick && ocm1 && (cnt == cmp1);
            out_hit  = hit_o[0];
        end
        drive = link || ocm0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pwm_q <= 1'b0;
        else if (drive) begin
            if (wrap && tov)           pwm_q <= 1'b1;
            else if (out_hit && !maxd) pwm_q <= 1'b0;
        end
    end

    assign pwm_o = pwm_q;
endmodule

// File: rtl/dualpwm_timer.sv
module dualpwm_timer
    import dpt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stop_i,
    input  logic          brk_i,
    input  logic          brk_clr_en_i,
    input  logic [1:0]    cap_i,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [W-1:0]  bus_wdata,
    output logic [W-1:0]  bus_rdata,
    output logic          pwm_o,
    output logic          irq_ovf_o,
    output logic [1:0]    irq_ch_o
);
    logic [W-1:0]     term_q, cnt_w;
    logic             run_q, ovf_ie_q, ovf_flag_q, ovf_arm_q;
    logic             tick_w, wrap_w, clr_ok, ovf_clr, main_we;
    logic [W-1:0]     cmp_w [2];
    logic [CTL_W-1:0] ctl_w [2];
    logic [1:0]       hit_w, cmp_we_w;

    assign clr_ok  = !brk_i || brk_clr_en_i;
    assign main_we = bus_wr && (bus_addr == RA_MAIN);
    assign ovf_clr = main_we && !bus_wdata[MB_FLAG] && ovf_arm_q && clr_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            term_q     <= '1;
            run_q      <= 1'b0;
            ovf_ie_q   <= 1'b0;
            ovf_flag_q <= 1'b0;
            ovf_arm_q  <= 1'b0;
        end else begin
            if (bus_wr && (bus_addr == RA_TERM)) term_q <= bus_wdata;
            if (main_we) begin
                run_q    <= bus_wdata[MB_RUN];
                ovf_ie_q <= bus_wdata[MB_IE];
            end
            if (wrap_w)       ovf_flag_q <= 1'b1;
            else if (ovf_clr) ovf_flag_q <= 1'b0;
            if (ovf_clr) ovf_arm_q <= 1'b0;
            else if (bus_rd && (bus_addr == RA_MAIN) && ovf_flag_q) ovf_arm_q <= 1'b1;
        end
    end

    dpt_count #(.W(W)) u_count (
        .clk(clk), .rst_n(rst_n), .run_en(run_q), .stop_i(stop_i), .brk_i(brk_i),
        .term_i(term_q), .cnt_o(cnt_w), .tick_o(tick_w), .wrap_o(wrap_w)
    );

    for (genvar i = 0; i < 2; i++) begin : g_ch
        localparam logic [AW-1:0] CMP_A = RA_CMP0 + AW'(i);
        localparam logic [AW-1:0] CTL_A = RA_CTL0 + AW'(i);
        assign cmp_we_w[i] = bus_wr && (bus_addr == CMP_A);
        dpt_chan #(.W(W)) u_chan (
            .clk(clk), .rst_n(rst_n),
            .cmp_we(cmp_we_w[i]),
            .ctl_we(bus_wr && (bus_addr == CTL_A)),
            .ctl_re(bus_rd && (bus_addr == CTL_A)),
            .clr_ok(clr_ok), .wdata(bus_wdata),
            .cap_i(cap_i[i]),
            .cap_en(!ctl_w[i][CB_OCM] && !ctl_w[0][CB_LINK]),
            .cnt_i(cnt_w), .hit_i(hit_w[i]),
            .cmp_o(cmp_w[i]), .ctl_o(ctl_w[i]), .irq_o(irq_ch_o[i])
        );
    end

    dpt_pwm #(.W(W)) u_pwm (
        .clk(clk), .rst_n(rst_n),
        .link(ctl_w[0][CB_LINK]), .ocm0(ctl_w[0][CB_OCM]), .ocm1(ctl_w[1][CB_OCM]),
        .tov(ctl_w[0][CB_TOV]), .maxd(ctl_w[0][CB_MAX]),
        .cmp0(cmp_w[0]), .cmp1(cmp_w[1]), .wr0(cmp_we_w[0]), .wr1(cmp_we_w[1]),
        .cnt(cnt_w), .tick(tick_w), .wrap(wrap_w), .pwm_o(pwm_o), .hit_o(hit_w)
    );

    always_comb begin
        unique case (bus_addr)
            RA_MAIN: bus_rdata = {{(W-3){1'b0}}, run_q, ovf_ie_q, ovf_flag_q};
            RA_TERM: bus_rdata = term_q;
            RA_CMP0: bus_rdata = cmp_w[0];
            RA_CMP1: bus_rdata = cmp_w[1];
            RA_CTL0: bus_rdata = {{(W-CTL_W){1'b0}}, ctl_w[0]};
            RA_CTL1: bus_rdata = {{(W-CTL_W){1'b0}}, ctl_w[1]};
            RA_CNT:  bus_rdata = cnt_w;
            default: bus_rdata = '0;
        endcase
    end

    assign irq_ovf_o = ovf_flag_q && ovf_ie_q;
endmodule

// File: rtl/dpt_chk.sv
module dpt_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         stop_i,
    input logic         brk_i,
    input logic         brk_clr_en_i,
    input logic [W-1:0] cnt,
    input logic [W-1:0] term,
    input logic         tick,
    input logic         ovf_flag,
    input logic         pwm,
    input logic         tov,
    input logic         maxd
);
    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt == term) |=> (cnt == '0)); // R1

    AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt == term) |=> ovf_flag); // R2

    AST_BRK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        brk_i |=> $stable(cnt)); // R5

    AST_BRK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_i && !brk_clr_en_i && ovf_flag) |=> ovf_flag); // R5

    AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> $stable(cnt)); // R6

    AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
        (!tov && !pwm) |=> !pwm); // R8

    AST_FULL_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
        (tov && maxd && pwm) |=> pwm); // R9
endmodule

bind dualpwm_timer dpt_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .brk_i(brk_i),
    .brk_clr_en_i(brk_clr_en_i), .cnt(cnt_w), .term(term_q), .tick(tick_w),
    .ovf_flag(ovf_flag_q), .pwm(pwm_o),
    .tov(ctl_w[0][dpt_pkg::CB_TOV]), .maxd(ctl_w[0][dpt_pkg::CB_MAX])
);

// File: tb/dualpwm_timer_tb.sv
module dualpwm_timer_tb;
    import dpt_pkg::*;

    localparam int CLK_PER = 10;
    localparam int W = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          stop_i = 1'b1;
    logic          brk_i = 1'b0;
    logic          brk_clr_en_i = 1'b0;
    logic [1:0]    cap_i = 2'b00;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [W-1:0]  bus_wdata = '0;
    logic [W-1:0]  bus_rdata;
    logic          pwm_o, irq_ovf_o;
    logic [1:0]    irq_ch_o;

    dualpwm_timer #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .brk_i(brk_i),
        .brk_clr_en_i(brk_clr_en_i), .cap_i(cap_i), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pwm_o(pwm_o), .irq_ovf_o(irq_ovf_o),
        .irq_ch_o(irq_ch_o)
    );

    always #(CLK_PER/2) clk = ~clk;

    int    total = 0;
    int    bad = 0;
    int    exp_q[$];
    string tag_q[$];
    bit    done = 1'b0;

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on every read strobe
    always @(negedge clk) begin
        #(CLK_PER/4);
        if (bus_rd) begin
            if (exp_q.size() == 0) check("scoreboard underflow", 1, 0);
            else check(tag_q.pop_front(), int'(bus_rdata), exp_q.pop_front());
        end
    end

    task automatic rd_exp(input logic [AW-1:0] a, input int e, input string t);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [AW-1:0] a, input int d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = W'(d);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic run_n(input int n, output int highs);
        highs = 0;
        @(negedge clk);
        stop_i = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            highs += int'(pwm_o);
        end
        stop_i = 1'b1;
    endtask

    initial begin
        #(CLK_PER * 20000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int h;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12 reset state
        check("R12 pwm after reset", int'(pwm_o), 0);
        check("R12 irq after reset", int'({irq_ch_o, irq_ovf_o}), 0);
        rd_exp(RA_MAIN, 0, "R12 main reg");
        rd_exp(RA_TERM, 16'hFFFF, "R12 terminal reset");
        rd_exp(RA_CNT, 0, "R12 count reset");

        // linked PWM, terminal 9, duty 3, toggle-on-wrap
        wr(RA_TERM, 9);
        wr(RA_CMP0, 3);
        wr(RA_CTL0, 32'h1C);
        wr(RA_MAIN, 4);
        run_n(10, h);
        check("R7 rise on wrap", int'(pwm_o), 1);
        rd_exp(RA_CNT, 0, "R1 wrap to zero");
        rd_exp(RA_MAIN, 5, "R2 overflow flag set");
        check("R2 irq gated by enable", int'(irq_ovf_o), 0);
        rd_exp(RA_CTL0, 32'h1D, "R11 channel 0 compare flag");

        // R3 clear protocol
        wr(RA_MAIN, 7);
        rd_exp(RA_MAIN, 7, "R3 write 1 no effect");
        check("R2 irq with enable", int'(irq_ovf_o), 1);
        wr(RA_MAIN, 6);
        rd_exp(RA_MAIN, 6, "R3 read then write 0 clears");
        run_n(10, h);
        wr(RA_MAIN, 6);
        rd_exp(RA_MAIN, 7, "R3 write 0 without read");

        // R5 break
        brk_i = 1'b1;
        wr(RA_MAIN, 6);
        rd_exp(RA_MAIN, 7, "R5 clear blocked in break");
        run_n(3, h);
        rd_exp(RA_CNT, 0, "R5 break halts count");
        brk_clr_en_i = 1'b1;
        wr(RA_MAIN, 6);
        rd_exp(RA_MAIN, 6, "R5 clear permitted in break");
        brk_i = 1'b0; brk_clr_en_i = 1'b0;

        // R10 buffered update
        run_n(2, h);
        wr(RA_CMP1, 1);
        run_n(2, h);
        check("R10 old duty kept mid-period", int'(pwm_o), 0);
        run_n(6, h);
        check("R7 rise on wrap again", int'(pwm_o), 1);
        run_n(2, h);
        check("R10 new duty after wrap", int'(pwm_o), 0);
        rd_exp(RA_CTL1, 1, "R11 channel 1 flag when in control");
        run_n(20, h);
        check("R7 duty 1 of terminal 9", h, 4);
        wr(RA_CMP0, 5);
        run_n(10, h);
        run_n(20, h);
        check("R10 control back to channel 0", h, 12);

        // R8 zero duty
        wr(RA_CTL0, 32'h0C);
        run_n(10, h);
        run_n(20, h);
        check("R8 zero duty", h, 0);

        // R9 full duty
        wr(RA_CTL0, 32'h3C);
        run_n(10, h);
        run_n(20, h);
        check("R9 full duty", h, 20);

        // R4 set and clear on the same clock (count now 2)
        rd_exp(RA_MAIN, 7, "R4 flag set before race");
        run_n(7, h);
        rd_exp(RA_CNT, 9, "R4 parked at terminal");
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = RA_MAIN; bus_wdata = 16'h6; stop_i = 1'b0;
        @(negedge clk);
        bus_wr = 1'b0; stop_i = 1'b1;
        rd_exp(RA_MAIN, 7, "R4 set wins over clear");

        // R6 stop freeze
        rd_exp(RA_CNT, 0, "R6 count held");
        repeat (5) @(negedge clk);
        rd_exp(RA_CNT, 0, "R6 count still held");
        rd_exp(RA_TERM, 9, "R6 registers kept");
        run_n(3, h);
        rd_exp(RA_CNT, 3, "R6 resume from held value");

        // R11 capture on channel 1
        wr(RA_CTL0, 0);
        rd_exp(RA_CTL1, 1, "R11 flag before clear");
        wr(RA_CTL1, 0);
        rd_exp(RA_CTL1, 0, "R3 channel flag cleared");
        @(negedge clk); cap_i[1] = 1'b1;
        @(negedge clk); @(negedge clk); cap_i[1] = 1'b0;
        rd_exp(RA_CMP1, 3, "R11 capture latches count");
        rd_exp(RA_CTL1, 1, "R11 capture sets flag");
        check("R11 irq gated by channel enable", int'(irq_ch_o[1]), 0);
        wr(RA_CTL1, 3);
        check("R11 irq with channel enable", int'(irq_ch_o[1]), 1);
        rd_exp(RA_CTL1, 3, "R3 channel write 1 keeps flag");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) check("scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule